// File: doc/BRIEF.md
# Memory Area Decoder with Swap

This block sits between an internal bus master and a set of external memory or peripheral devices. The upper bits of each bus address pick one of four contiguous 1 MB windows. The block decodes that window to one of four device areas and drives an active-low select line for it, together with an active-low read strobe, active-low byte write strobes and a data output enable. The master issues one request at a time. It waits for a one-cycle completion pulse that carries the read data.

Each area has its own configuration byte. The byte sets the number of wait cycles per device access, the number of idle recovery cycles after each access, and the data width of the device (8, 16 or 32 bits). When a bus transfer is wider than the device, the block splits it into consecutive narrower accesses in ascending address order. It steers each byte to the correct lane on both sides. A device can stretch any access with an external wait input. A swap bit exchanges the first and last areas. This lets the system start from the boot device in area 1 and later place fast RAM, normally in area 4, at address zero.

Top module: `mem_area_decoder`

## Requirements
- R1: Out of reset all selects, the read strobe and the write strobes are high, the data output enable is low and `bus_ready` is high.
- R2: Bus address bits [21:20] form the window number w. With the swap bit clear, an access to window w drives `mem_cs_n[w]` low and leaves every other select high.
- R3: With the swap bit set, window 0 selects area 3 (`mem_cs_n[3]`), window 3 selects area 0, and windows 1 and 2 are unchanged. The swapped area's own configuration applies.
- R4: A change of the swap bit during a transfer does not affect any access of that transfer. It takes effect from the next accepted request.
- R5: With a wait field of W and no external wait, each device access holds its select and strobes for exactly W+1 cycles.
- R6: Each rising clock edge that samples `mem_wait` high during an access lengthens that access by one cycle, with select and address held.
- R7: With a stop field of S, each device access is followed by S cycles with all selects and strobes inactive, before the next access of the same transfer or before `bus_ready` returns.
- R8: A transfer of 2^s bytes to a device of 2^d bytes with s > d runs as 2^(s-d) accesses at ascending byte addresses. Each access applies the full wait count. `bus_done` pulses once, in the cycle after the last access.
- R9: Bus byte b of the 32-bit data word belongs to byte address with low bits b. The device lane for byte address x is x mod (device bytes). Writes place bus bytes on these lanes and pull the matching `mem_we_n` bits low. Reads return them on the same bus byte, and all other bus bytes read zero.
- R10: `mem_addr` carries the full byte address of the current access, so its bit 0 acts as the lower-byte select. `mem_ub_n` is low exactly when device lane 1 is in use during an access.
- R11: `mem_oe_n` is low only during read accesses. `mem_dout_en` is high only during write accesses. Outside a write access the data outputs are treated as high impedance.
- R12: Configuration writes use `cfg_sel` 0 to 3 for the area bytes, laid out as [3:0] wait count, [5:4] stop count, [7:6] width (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit). `cfg_sel` 4 writes the swap bit from bit 0. Reset values are wait 15, stop 3, 16-bit, swap 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Request, accepted when `bus_ready` is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Log2 of transfer bytes (0 byte, 1 half, 2 word) |
| bus_addr | input | 22 | Byte address: [21:20] window, [19:0] offset |
| bus_wdata | input | 32 | Write data, little-endian byte lanes |
| bus_ready | output | 1 | Idle and able to accept a request |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid from `bus_done` onwards |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| mem_cs_n | output | 4 | Active-low area selects |
| mem_addr | output | 20 | Byte address within the area |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 4 | Active-low per-lane write strobes |
| mem_ub_n | output | 1 | Active-low upper-byte select for 16-bit devices |
| mem_dout | output | 32 | Device write data |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 32 | Device read data |
| mem_wait | input | 1 | Device wait request |

## Verification
The hardest situation to reach is a swap-bit change that lands in the middle of a multi-access transfer. The ports only allow it while a slow, split access is in progress. The bench sets up a 16-bit area with a long wait count behind the swapped window. It starts a word read there and, in a parallel thread, clears the swap bit a few cycles into the first half-word access. It then checks that both half-word accesses stayed on the same select and that the next transfer uses the unswapped map. External wait stretching is exercised the same way, by raising `mem_wait` for a counted number of edges once the first strobe cycle is seen.

// File: rtl/mad_pkg.sv
// Shared types for the memory area decoder.
// Assumes an 8-bit per-area configuration byte: {width, stop, waits}.
package mad_pkg;
    localparam int WAIT_W = 4;
    localparam int STOP_W = 2;
    localparam int WID_W  = 2;
    localparam int CFG_W  = WAIT_W + STOP_W + WID_W;

    typedef struct packed {
        logic [WID_W-1:0]  width;
        logic [STOP_W-1:0] stop;
        logic [WAIT_W-1:0] waits;
    } area_cfg_t;

    localparam area_cfg_t CFG_RESET = '{width: 2'd1, stop: 2'd3, waits: 4'hF};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_STOP = 2'd2
    } seq_state_e;

    // Width code to log2 of device bytes (code 3 behaves as 32-bit).
    function automatic logic [1:0] dev_lg_of(input logic [WID_W-1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction
endpackage

// File: rtl/mad_cfg_bank.sv
// Configuration storage: one timing/width byte per area plus the swap bit.
// Assumes selects 0..NUM_AREAS-1 address the area bytes and NUM_AREAS the swap bit.
module mad_cfg_bank
    import mad_pkg::*;
#(
    parameter int NUM_AREAS = 4,
    parameter int SEL_W     = $clog2(NUM_AREAS + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [SEL_W-1:0]                 cfg_sel,
    input  logic [CFG_W-1:0]                 cfg_wdata,
    output area_cfg_t [NUM_AREAS-1:0]        area_cfg,
    output logic                             swap_en
);
    // Area configuration bytes, reset to the slow boot-safe timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_AREAS; i++) area_cfg[i] <= CFG_RESET;
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_AREAS; i++)
                if (cfg_sel == SEL_W'(i)) area_cfg[i] <= area_cfg_t'(cfg_wdata);
        end
    end

    // Swap bit, cleared by reset so area 1 serves the boot window.
    always_ff @(posedge clk) begin
        if (!rst_n) swap_en <= 1'b0;
        else if (cfg_we && cfg_sel == SEL_W'(NUM_AREAS)) swap_en <= cfg_wdata[0];
    end
endmodule

// File: rtl/mad_window_map.sv
// Maps an address window number to a physical area, exchanging the first
// and last areas when the swap bit is set. Purely combinational.
module mad_window_map #(
    parameter int NUM_AREAS = 4,
    parameter int IDX_W     = $clog2(NUM_AREAS)
) (
    input  logic [IDX_W-1:0] win_idx,
    input  logic             swap_en,
    output logic [IDX_W-1:0] area_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_AREAS - 1);

    // Swap first and last window; pass the rest through.
    always_comb begin
        area_idx = win_idx;
        if (swap_en) begin
            if (win_idx == '0)       area_idx = LAST;
            else if (win_idx == LAST) area_idx = '0;
        end
    end
endmodule

// File: rtl/mad_lane_steer.sv
// Byte-lane steering for one device access. Maps bus byte lanes to device
// lanes for writes and device lanes back into the bus word for reads.
// Assumes accesses are naturally aligned to their size.
module mad_lane_steer #(
    parameter int DATA_W = 32,
    parameter int BYTES  = DATA_W / 8,
    parameter int LANE_W = $clog2(BYTES),
    parameter int LG_W   = $clog2(LANE_W + 1)
) (
    input  logic [LANE_W-1:0] beat_lo,
    input  logic [LG_W-1:0]   beat_lg,
    input  logic [LG_W-1:0]   dev_lg,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] mem_din,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [DATA_W-1:0] dev_wdata,
    output logic [BYTES-1:0]  lane_en,
    output logic [DATA_W-1:0] rdata_out
);
    // Walk the bytes of this access and route each one.
    always_comb begin
        logic [LANE_W-1:0] bl;
        logic [LANE_W-1:0] dl;
        logic [LANE_W-1:0] dmask;
        dmask     = LANE_W'((1 << dev_lg) - 1);
        lane_en   = '0;
        dev_wdata = '0;
        rdata_out = rdata_in;
        for (int j = 0; j < BYTES; j++) begin
            bl = beat_lo + LANE_W'(j);
            dl = bl & dmask;
            if (j < (1 << beat_lg)) begin
                lane_en[dl]          = 1'b1;
                dev_wdata[dl*8 +: 8] = bus_wdata[bl*8 +: 8];
                rdata_out[bl*8 +: 8] = mem_din[dl*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/mad_seq.sv
// Access sequencer: counts wait cycles, honours the external wait, inserts
// stop cycles and steps through the accesses of a split transfer.
// Assumes the load values are stable for the whole transfer except at start.
module mad_seq
    import mad_pkg::*;
#(
    parameter int BEAT_W = 2,
    parameter int CNT_W  = (WAIT_W > STOP_W) ? WAIT_W : STOP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] ld_waits,
    input  logic [STOP_W-1:0] ld_stop,
    input  logic [BEAT_W-1:0] last_beat,
    input  logic              mem_wait,
    output logic              in_acc,
    output logic              idle,
    output logic              beat_end,
    output logic              fin_end,
    output logic [BEAT_W-1:0] beat_idx
);
    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             fin;
    logic             is_last;

    assign in_acc   = (st == ST_ACC);
    assign idle     = (st == ST_IDLE);
    assign is_last  = (beat_idx == last_beat);
    assign beat_end = in_acc && !mem_wait && (cnt == '0);
    assign fin_end  = beat_end && is_last;

    // State, cycle counter and access index of the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            fin      <= 1'b0;
            beat_idx <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    st       <= ST_ACC;
                    cnt      <= CNT_W'(ld_waits);
                    beat_idx <= '0;
                    fin      <= 1'b0;
                end
                ST_ACC: if (!mem_wait) begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        fin <= is_last;
                        if (!is_last) beat_idx <= beat_idx + 1'b1;
                        if (ld_stop != '0) begin
                            st  <= ST_STOP;
                            cnt <= CNT_W'(ld_stop) - 1'b1;
                        end else if (is_last) begin
                            st <= ST_IDLE;
                        end else begin
                            cnt <= CNT_W'(ld_waits);
                        end
                    end
                end
                ST_STOP: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else if (fin)  st  <= ST_IDLE;
                    else begin
                        st  <= ST_ACC;
                        cnt <= CNT_W'(ld_waits);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mem_area_decoder.sv
// Memory area decoder: decodes a bus address into one of NUM_AREAS device
// areas (with first/last swap), runs each access with per-area wait and stop
// timing, splits transfers wider than the device and steers byte lanes.
// Assumes one outstanding request, accepted only while bus_ready is high.
module mem_area_decoder
    import mad_pkg::*;
#(
    parameter int NUM_AREAS = 4,
    parameter int AREA_AW   = 20,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_AREAS),
    localparam int ADDR_W   = AREA_AW + IDX_W,
    localparam int BYTES    = DATA_W / 8,
    localparam int LANE_W   = $clog2(BYTES),
    localparam int LG_W     = $clog2(LANE_W + 1),
    localparam int SEL_W    = $clog2(NUM_AREAS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [LG_W-1:0]      bus_size,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 bus_ready,
    output logic                 bus_done,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [NUM_AREAS-1:0] mem_cs_n,
    output logic [AREA_AW-1:0]   mem_addr,
    output logic                 mem_oe_n,
    output logic [BYTES-1:0]     mem_we_n,
    output logic                 mem_ub_n,
    output logic [DATA_W-1:0]    mem_dout,
    output logic                 mem_dout_en,
    input  logic [DATA_W-1:0]    mem_din,
    input  logic                 mem_wait
);
    area_cfg_t [NUM_AREAS-1:0] area_cfg;
    logic                      swap_en;
    logic [IDX_W-1:0]          area_new;
    logic                      accept;

    logic [IDX_W-1:0]   lat_area;
    area_cfg_t          lat_cfg;
    area_cfg_t          cur_cfg;
    logic [AREA_AW-1:0] lat_addr;
    logic               lat_we;
    logic [LG_W-1:0]    lat_size;
    logic [DATA_W-1:0]  lat_wdata;

    logic [LG_W-1:0]    eff_size;
    logic [LG_W-1:0]    dev_lg;
    logic [LG_W-1:0]    beat_lg;
    logic [LANE_W-1:0]  last_beat;
    logic [AREA_AW-1:0] beat_addr;

    logic               in_acc;
    logic               seq_idle;
    logic               beat_end;
    logic               fin_end;
    logic [LANE_W-1:0]  beat_idx;

    logic [DATA_W-1:0]  dev_wdata;
    logic [BYTES-1:0]   lane_en;
    logic [DATA_W-1:0]  rdata_next;
    logic               done_q;

    mad_cfg_bank #(.NUM_AREAS(NUM_AREAS), .SEL_W(SEL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .area_cfg  (area_cfg),
        .swap_en   (swap_en)
    );

    mad_window_map #(.NUM_AREAS(NUM_AREAS), .IDX_W(IDX_W)) u_map (
        .win_idx  (bus_addr[ADDR_W-1 -: IDX_W]),
        .swap_en  (swap_en),
        .area_idx (area_new)
    );

    assign bus_ready = seq_idle;
    assign accept    = bus_req && seq_idle;
    assign cur_cfg   = seq_idle ? area_cfg[area_new] : lat_cfg;

    // Capture the request and its area configuration at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_area  <= '0;
            lat_cfg   <= CFG_RESET;
            lat_addr  <= '0;
            lat_we    <= 1'b0;
            lat_size  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_area  <= area_new;
            lat_cfg   <= area_cfg[area_new];
            lat_addr  <= bus_addr[AREA_AW-1:0];
            lat_we    <= bus_we;
            lat_size  <= bus_size;
            lat_wdata <= bus_wdata;
        end
    end

    // Derive access width, access count and the current access address.
    always_comb begin
        eff_size  = (lat_size > LG_W'(LANE_W)) ? LG_W'(LANE_W) : lat_size;
        dev_lg    = (LG_W'(dev_lg_of(lat_cfg.width)) > LG_W'(LANE_W)) ?
                    LG_W'(LANE_W) : LG_W'(dev_lg_of(lat_cfg.width));
        beat_lg   = (eff_size < dev_lg) ? eff_size : dev_lg;
        last_beat = (eff_size > dev_lg) ?
                    LANE_W'((1 << (eff_size - dev_lg)) - 1) : '0;
        beat_addr = lat_addr + (AREA_AW'(beat_idx) << beat_lg);
    end

    mad_seq #(.BEAT_W(LANE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .ld_waits  (cur_cfg.waits),
        .ld_stop   (cur_cfg.stop),
        .last_beat (last_beat),
        .mem_wait  (mem_wait),
        .in_acc    (in_acc),
        .idle      (seq_idle),
        .beat_end  (beat_end),
        .fin_end   (fin_end),
        .beat_idx  (beat_idx)
    );

    mad_lane_steer #(.DATA_W(DATA_W)) u_lanes (
        .beat_lo   (beat_addr[LANE_W-1:0]),
        .beat_lg   (beat_lg),
        .dev_lg    (dev_lg),
        .bus_wdata (lat_wdata),
        .mem_din   (mem_din),
        .rdata_in  (bus_rdata),
        .dev_wdata (dev_wdata),
        .lane_en   (lane_en),
        .rdata_out (rdata_next)
    );

    // Read data assembly and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= fin_end;
            if (accept) bus_rdata <= '0;
            else if (beat_end && !lat_we) bus_rdata <= rdata_next;
        end
    end
    assign bus_done = done_q;

    // One active-low select per area.
    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cs
        assign mem_cs_n[g] = !(in_acc && (lat_area == IDX_W'(g)));
    end

    assign mem_addr    = beat_addr;
    assign mem_oe_n    = !(in_acc && !lat_we);
    assign mem_we_n    = (in_acc && lat_we) ? ~lane_en : '1;
    assign mem_ub_n    = !(in_acc && lane_en[1]);
    assign mem_dout    = dev_wdata;
    assign mem_dout_en = in_acc && lat_we;
endmodule

// File: rtl/mad_checker.sv
// Protocol checker for mem_area_decoder, attached with bind below.
// Assumes it sees only the top-level ports.
module mad_checker #(
    parameter int NUM_AREAS = 4,
    parameter int AREA_AW   = 20,
    parameter int BYTES     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req,
    input logic                 bus_ready,
    input logic                 bus_done,
    input logic [NUM_AREAS-1:0] mem_cs_n,
    input logic [AREA_AW-1:0]   mem_addr,
    input logic                 mem_oe_n,
    input logic [BYTES-1:0]     mem_we_n,
    input logic                 mem_dout_en,
    input logic                 mem_wait
);
    // R2: never more than one area selected.
    p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R11: read strobe and write drive never overlap.
    p_oe_dout_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && mem_dout_en));

    // R11: any strobe or data drive implies a selected area.
    p_strobe_needs_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || mem_dout_en || (mem_we_n != '1)) |-> (mem_cs_n != '1));

    // R1: while idle nothing is selected or driven.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> ((mem_cs_n == '1) && mem_oe_n && !mem_dout_en));

    // R5: an accepted request starts an access on the next cycle.
    p_accept_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready) |=> (!bus_ready && (mem_cs_n != '1)));

    // R6: external wait freezes select and address for another cycle.
    p_ext_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wait && (mem_cs_n != '1)) |=> ($stable(mem_cs_n) && $stable(mem_addr)));

    // R8: completion is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |=> !bus_done);
endmodule

bind mem_area_decoder mad_checker #(
    .NUM_AREAS (NUM_AREAS),
    .AREA_AW   (AREA_AW),
    .BYTES     (BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_ready   (bus_ready),
    .bus_done    (bus_done),
    .mem_cs_n    (mem_cs_n),
    .mem_addr    (mem_addr),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dout_en (mem_dout_en),
    .mem_wait    (mem_wait)
);

// File: tb/mem_area_decoder_tb.sv
// Directed bench for mem_area_decoder: one task per scenario, each checking
// its own results against values derived from the requirements.
module mem_area_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [21:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_done;
    logic [31:0] bus_rdata;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [3:0]  mem_cs_n;
    logic [19:0] mem_addr;
    logic        mem_oe_n, mem_ub_n, mem_dout_en;
    logic [3:0]  mem_we_n;
    logic [31:0] mem_dout, mem_din;
    logic        mem_wait = 1'b0;

    always #5 clk = ~clk;

    mem_area_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_wait(mem_wait)
    );

    // Device models: 64 bytes per area, width as configured by the bench.
    logic [7:0] dev_mem [4][64];
    logic [1:0] dev_lg  [4] = '{2'd1, 2'd1, 2'd1, 2'd1};

    always_comb begin
        logic [5:0] b;
        mem_din = '0;
        for (int k = 0; k < 4; k++) begin
            b = mem_addr[5:0] & ~6'((1 << dev_lg[k]) - 1);
            if (!mem_cs_n[k])
                for (int l = 0; l < 4; l++)
                    if (l < (1 << dev_lg[k])) mem_din[l*8 +: 8] = dev_mem[k][b + 6'(l)];
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++)
                for (int i = 0; i < 64; i++) dev_mem[k][i] <= 8'(k*64 + i);
        end else begin
            for (int k = 0; k < 4; k++)
                if (!mem_cs_n[k])
                    for (int l = 0; l < 4; l++)
                        if (!mem_we_n[l])
                            dev_mem[k][(mem_addr[5:0] & ~6'((1 << dev_lg[k]) - 1)) + 6'(l)]
                                <= mem_dout[l*8 +: 8];
        end
    end

    int n_vec = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Results of the last transfer.
    logic [31:0] r_rdata;
    int          r_strobes, r_beats, r_gap, r_cs;
    bit          r_mixed, r_bad_strobe, r_ub;
    logic [3:0]  r_we;
    logic [19:0] r_addr [4];

    task automatic xfer(input bit we, input logic [1:0] size, input logic [21:0] addr,
                        input logic [31:0] wd, input int ext_w);
        int          wl;
        logic [19:0] prev_a;
        bit          seen;
        r_strobes = 0; r_beats = 0; r_gap = 0; r_cs = -1; r_mixed = 0;
        r_bad_strobe = 0; r_ub = 1; r_we = 4'hF; r_rdata = 'x;
        wl = ext_w; prev_a = '0; seen = 0;
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_size = size; bus_addr = addr; bus_wdata = wd;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            bus_req = 1'b0;
            if (bus_done) begin
                r_rdata = bus_rdata;
                break;
            end
            if (mem_cs_n != 4'hF) begin
                int idx;
                idx = 0;
                for (int k = 0; k < 4; k++) if (!mem_cs_n[k]) idx = k;
                if (r_cs >= 0 && idx != r_cs) r_mixed = 1;
                r_cs = idx;
                r_strobes++;
                if (!seen || mem_addr != prev_a) begin
                    if (r_beats < 4) r_addr[r_beats] = mem_addr;
                    if (r_beats == 0) begin r_ub = mem_ub_n; r_we = mem_we_n; end
                    r_beats++;
                end
                seen = 1; prev_a = mem_addr;
                if (we ? (mem_oe_n !== 1'b1 || mem_dout_en !== 1'b1)
                       : (mem_oe_n !== 1'b0 || mem_dout_en !== 1'b0 || mem_we_n !== 4'hF))
                    r_bad_strobe = 1;
            end else begin
                if (r_beats > 0) r_gap++;
                if (mem_oe_n !== 1'b1 || mem_dout_en !== 1'b0 || mem_we_n !== 4'hF)
                    r_bad_strobe = 1;
            end
            if (r_strobes >= 1 && wl > 0) begin mem_wait = 1'b1; wl--; end
            else mem_wait = 1'b0;
        end
        mem_wait = 1'b0;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk("R1 ready", 32'(bus_ready), 32'd1);
        chk("R1 cs_n", 32'(mem_cs_n), 32'hF);
        chk("R1 oe_n/we_n", {27'd0, mem_oe_n, mem_we_n}, {27'd0, 1'b1, 4'hF});
        chk("R1 dout_en", 32'(mem_dout_en), 32'd0);
    endtask

    task automatic t_default_timing;
        // R12 reset config: wait 15, stop 3, 16-bit; R8 split into two half-words.
        xfer(0, 2'd2, 22'h000000, 0, 0);
        chk("R12 default cs", 32'(r_cs), 32'd0);
        chk("R12/R5 strobes 2x16", 32'(r_strobes), 32'd32);
        chk("R8 beats", 32'(r_beats), 32'd2);
        chk("R8 order", {r_addr[0][15:0], r_addr[1][15:0]}, 32'h0000_0002);
        chk("R7 stop gap", 32'(r_gap), 32'd3);
        chk("R9 rdata", r_rdata, 32'h0302_0100);
        chk("R11 strobes", 32'(r_bad_strobe), 32'd0);
    endtask

    task automatic t_decode;
        for (int k = 0; k < 4; k++) begin
            cfg_write(3'(k), 8'h81);
            dev_lg[k] = 2'd2;
        end
        for (int k = 0; k < 4; k++) begin
            xfer(1, 2'd2, 22'((k << 20) | 4), 32'hC0DE_0000 | 32'(k), 0);
            chk("R2 write cs", 32'(r_cs), 32'(k));
            chk("R5 one wait", 32'(r_strobes), 32'd2);
            chk("R11 write strobes", 32'(r_bad_strobe), 32'd0);
            xfer(0, 2'd2, 22'((k << 20) | 4), 0, 0);
            chk("R2 readback", r_rdata, 32'hC0DE_0000 | 32'(k));
        end
    endtask

    task automatic t_lanes16;
        cfg_write(3'd1, 8'h50); dev_lg[1] = 2'd1;
        xfer(1, 2'd0, 22'h100003, 32'hAB00_0000, 0);
        chk("R10 odd addr bit0", 32'(r_addr[0]), 32'h00003);
        chk("R10 ub_n odd byte", 32'(r_ub), 32'd0);
        chk("R9 we lanes", 32'(r_we), 32'hD);
        @(negedge clk);
        chk("R9 dev byte 3", 32'(dev_mem[1][3]), 32'hAB);
        chk("R9 dev byte 2 kept", 32'(dev_mem[1][2]), 32'h42);
        xfer(0, 2'd0, 22'h100002, 0, 0);
        chk("R10 ub_n even byte", 32'(r_ub), 32'd1);
        chk("R9 byte read lane", r_rdata, 32'h0042_0000);
        xfer(0, 2'd1, 22'h100002, 0, 0);
        chk("R10 ub_n half", 32'(r_ub), 32'd0);
        chk("R9 half read", r_rdata, 32'hAB42_0000);
    endtask

    task automatic t_split8;
        cfg_write(3'd2, 8'h01); dev_lg[2] = 2'd0;
        xfer(1, 2'd2, 22'h200008, 32'h4433_2211, 0);
        chk("R8 byte beats", 32'(r_beats), 32'd4);
        chk("R8 byte order", {r_addr[0][7:0], r_addr[1][7:0], r_addr[2][7:0], r_addr[3][7:0]},
            32'h0809_0A0B);
        chk("R8 full wait each", 32'(r_strobes), 32'd8);
        @(negedge clk);
        chk("R9 byte dev", {dev_mem[2][11], dev_mem[2][10], dev_mem[2][9], dev_mem[2][8]},
            32'h4433_2211);
        xfer(0, 2'd2, 22'h200008, 0, 0);
        chk("R9 byte readback", r_rdata, 32'h4433_2211);
    endtask

    task automatic t_waits;
        cfg_write(3'd3, 8'h85); dev_lg[3] = 2'd2;
        xfer(0, 2'd2, 22'h300000, 0, 0);
        chk("R5 wait 5", 32'(r_strobes), 32'd6);
        chk("R5 rdata", r_rdata, 32'hC3C2_C1C0);
        xfer(0, 2'd2, 22'h300000, 0, 2);
        chk("R6 ext wait +2", 32'(r_strobes), 32'd8);
        chk("R6 rdata", r_rdata, 32'hC3C2_C1C0);
    endtask

    task automatic t_swap;
        cfg_write(3'd4, 8'h01);
        xfer(0, 2'd2, 22'h000000, 0, 0);
        chk("R3 window0 -> cs3", 32'(r_cs), 32'd3);
        chk("R3 area3 timing", 32'(r_strobes), 32'd6);
        chk("R3 rdata", r_rdata, 32'hC3C2_C1C0);
        xfer(0, 2'd2, 22'h100004, 0, 0);
        chk("R3 window1 unchanged", 32'(r_cs), 32'd1);
        chk("R3 window1 rdata", r_rdata, 32'hC0DE_0001);
    endtask

    task automatic t_swap_inflight;
        cfg_write(3'd0, 8'h67); dev_lg[0] = 2'd1;
        fork
            xfer(0, 2'd2, 22'h300000, 0, 0);
            begin
                repeat (5) @(negedge clk);
                cfg_write(3'd4, 8'h00);
            end
        join
        chk("R4 in-flight cs", 32'(r_cs), 32'd0);
        chk("R4 no cs change", 32'(r_mixed), 32'd0);
        chk("R4 beats", 32'(r_beats), 32'd2);
        chk("R4/R5 strobes", 32'(r_strobes), 32'd16);
        chk("R7 gap 2", 32'(r_gap), 32'd2);
        chk("R4 rdata", r_rdata, 32'h0302_0100);
        xfer(0, 2'd2, 22'h300000, 0, 0);
        chk("R4 next uses new map", 32'(r_cs), 32'd3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset_state();
        t_default_timing();
        t_decode();
        t_lanes16();
        t_split8();
        t_waits();
        t_swap();
        t_swap_inflight();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule